// File: doc/BRIEF.md
# Commit-Gated Store Queue

This block holds the stores of an out-of-order core between dispatch and the data cache. Each store takes a slot at the tail together with its address, data, byte size and sequence number. Stores stay speculative until the commit stage reports a sequence number. Every store at or below that number, taken in program order, then becomes eligible to write. A writeback pointer sits between head and tail and walks the eligible stores. It offers each one to the cache through a valid/ready request. If the cache refuses a request, the same request is held until the cache signals a retry.

The cache answers each write with the slot index, and answers may come in any order. The head only moves when the slot it points at has completed. In that cycle it skips over every completed slot that follows, as far as the tail. A squash pulls the tail back over younger speculative stores, and a committed store is never removed. One slot is always kept empty so that a full queue can be told apart from an empty one. The free-slot output reports how much room the core has for new memory operations.

The writeback engine is a three-state machine:
- **WB_SCAN** looks at the store under the writeback pointer. A zero-size store is completed on the spot. A sized store moves the machine to WB_SEND when the cache is not busy.
- **WB_SEND** drives the request. On accept it advances the pointer and returns to WB_SCAN. On refusal it goes to WB_WAIT_RETRY.
- **WB_WAIT_RETRY** keeps the request off the bus until the retry pulse, then returns to WB_SEND.

Top module: `store_queue`

## Requirements
- R1: After reset the queue is empty: `alloc_idx` is 0, `req_valid` is 0, and `free_slots` follows R10 with zero stores held.
- R2: An accepted allocation writes the slot at `alloc_idx`, which then advances by one modulo DEPTH. When DEPTH-1 stores are held, an allocation is ignored and `alloc_idx` and `free_slots` stay unchanged.
- R3: A commit with number C walks from the head. It marks every unmarked store whose sequence number is at most C and stops at the first unmarked store above C. A store that was never marked is never requested.
- R4: Marked stores are requested in slot order, one request at a time, with `req_idx`, `req_addr`, `req_data` and `req_size` taken from that slot. The request is raised two cycles after the commit cycle, and an accepted request drops for at least one cycle.
- R5: A marked store of size 0 is completed without any request, one cycle after it reaches the writeback pointer. This does not happen in a cycle that carries a response.
- R6: A request seen with `req_ready` low is withdrawn in the next cycle. It is offered again, with the same index, in the cycle after a `cache_retry` pulse.
- R7: No request is raised while `cache_busy` is high, nor while a refused request waits for its retry.
- R8: A response with `resp_idx` completes that slot. Only the head releases space, and it then also releases every consecutive completed slot behind it, so a completion away from the head frees nothing.
- R9: A squash with number S removes stores from the tail downward while their number exceeds S. It stops at the first store that is marked for writeback. Allocation and commit are ignored in a squash cycle.
- R10: `free_slots` equals min(LQ_DEPTH - `lq_used`, DEPTH - stores held) - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a store at the tail |
| alloc_addr | input | ADDR_W | Store address |
| alloc_data | input | DATA_W | Store data |
| alloc_size | input | SIZE_W | Store size in bytes; 0 means no memory write |
| alloc_seq | input | SEQ_W | Store sequence number |
| alloc_idx | output | IDX_W | Slot the next allocation takes (the tail) |
| commit_valid | input | 1 | Commit pulse |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash pulse |
| squash_seq | input | SEQ_W | Stores younger than this are removed |
| lq_used | input | LQ_CNT_W | Loads currently held in the load queue |
| free_slots | output | FREE_W | Room for new memory operations |
| cache_busy | input | 1 | Cache cannot take a new request |
| req_valid | output | 1 | Write request valid |
| req_idx | output | IDX_W | Slot of the requested store |
| req_addr | output | ADDR_W | Request address |
| req_data | output | DATA_W | Request data |
| req_size | output | SIZE_W | Request size |
| req_ready | input | 1 | Cache accepts the request |
| cache_retry | input | 1 | Cache invites a refused request again |
| resp_valid | input | 1 | Write response |
| resp_idx | input | IDX_W | Slot the response completes |

## Verification
A broken head, tail or writeback pointer shows at the ports almost at once. The stale pointer appears on `alloc_idx` or `req_idx` in the next cycle, and a bad occupancy shows up in `free_slots` in the cycle after the faulty update. A wrong eligibility bit shows when a request is raised for an uncommitted store, or is missing two cycles after its commit. A wrong completion bit shows when `free_slots` fails to jump after the head's response, or jumps after an out-of-order one. The bench pins each of these to the exact cycle in which the visible change is due.

// File: rtl/sq_pkg.sv
package sq_pkg;
    typedef enum logic [1:0] {
        WB_SCAN       = 2'd0,
        WB_SEND       = 2'd1,
        WB_WAIT_RETRY = 2'd2
    } wb_state_t;
endpackage

// File: rtl/sq_commit_scan.sv
module sq_commit_scan #(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 16
) (
    input  logic [$clog2(DEPTH)-1:0]   head,
    input  logic [$clog2(DEPTH+1)-1:0] occ,
    input  logic [DEPTH-1:0]           elig,
    input  logic [DEPTH-1:0][SEQ_W-1:0] seq,
    input  logic                       en,
    input  logic [SEQ_W-1:0]           limit,
    output logic [DEPTH-1:0]           mark,
    output logic [$clog2(DEPTH+1)-1:0] mark_cnt
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] b, input int off);
        int s;
        s = int'(b) + off;
        if (s >= DEPTH) s = s - DEPTH;
        return IDX_W'(s);
    endfunction

    always_comb begin
        logic stop;
        logic [IDX_W-1:0] idx;
        mark     = '0;
        mark_cnt = '0;
        stop     = !en;
        for (int k = 0; k < DEPTH - 1; k++) begin
            idx = step(head, k);
            if (!stop && (k < int'(occ)) && !elig[idx]) begin
                if (seq[idx] <= limit) begin
                    mark[idx] = 1'b1;
                    mark_cnt  = mark_cnt + CNT_W'(1);
                end else begin
                    stop = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sq_squash_scan.sv
module sq_squash_scan #(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 16
) (
    input  logic [$clog2(DEPTH)-1:0]   tail,
    input  logic [$clog2(DEPTH+1)-1:0] occ,
    input  logic [DEPTH-1:0]           elig,
    input  logic [DEPTH-1:0][SEQ_W-1:0] seq,
    input  logic                       en,
    input  logic [SEQ_W-1:0]           limit,
    output logic [DEPTH-1:0]           kill,
    output logic [$clog2(DEPTH+1)-1:0] kill_cnt
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    function automatic logic [IDX_W-1:0] back(input logic [IDX_W-1:0] b, input int off);
        int s;
        s = int'(b) - off;
        if (s < 0) s = s + DEPTH;
        return IDX_W'(s);
    endfunction

    always_comb begin
        logic stop;
        logic [IDX_W-1:0] idx;
        kill     = '0;
        kill_cnt = '0;
        stop     = !en;
        for (int k = 0; k < DEPTH - 1; k++) begin
            idx = back(tail, k + 1);
            if (!stop && (k < int'(occ))) begin
                if (elig[idx] || (seq[idx] <= limit)) begin
                    stop = 1'b1;
                end else begin
                    kill[idx] = 1'b1;
                    kill_cnt  = kill_cnt + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/sq_retire_scan.sv
module sq_retire_scan #(
    parameter int DEPTH = 8
) (
    input  logic [$clog2(DEPTH)-1:0]   head,
    input  logic [$clog2(DEPTH+1)-1:0] occ,
    input  logic [DEPTH-1:0]           done,
    output logic [DEPTH-1:0]           retire,
    output logic [$clog2(DEPTH+1)-1:0] ret_cnt
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] b, input int off);
        int s;
        s = int'(b) + off;
        if (s >= DEPTH) s = s - DEPTH;
        return IDX_W'(s);
    endfunction

    always_comb begin
        logic stop;
        logic [IDX_W-1:0] idx;
        retire  = '0;
        ret_cnt = '0;
        stop    = 1'b0;
        for (int k = 0; k < DEPTH - 1; k++) begin
            idx = step(head, k);
            if (!stop && (k < int'(occ)) && done[idx]) begin
                retire[idx] = 1'b1;
                ret_cnt     = ret_cnt + CNT_W'(1);
            end else begin
                stop = 1'b1;
            end
        end
    end
endmodule

// File: rtl/store_queue.sv
module store_queue #(
    parameter int DEPTH    = 8,
    parameter int LQ_DEPTH = 8,
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int SIZE_W   = 4,
    parameter int SEQ_W    = 16,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int LQ_CNT_W = $clog2(LQ_DEPTH + 1),
    localparam int FREE_W   = $clog2(((DEPTH > LQ_DEPTH) ? DEPTH : LQ_DEPTH) + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc_valid,
    input  logic [ADDR_W-1:0]   alloc_addr,
    input  logic [DATA_W-1:0]   alloc_data,
    input  logic [SIZE_W-1:0]   alloc_size,
    input  logic [SEQ_W-1:0]    alloc_seq,
    output logic [IDX_W-1:0]    alloc_idx,
    input  logic                commit_valid,
    input  logic [SEQ_W-1:0]    commit_seq,
    input  logic                squash_valid,
    input  logic [SEQ_W-1:0]    squash_seq,
    input  logic [LQ_CNT_W-1:0] lq_used,
    output logic [FREE_W-1:0]   free_slots,
    input  logic                cache_busy,
    output logic                req_valid,
    output logic [IDX_W-1:0]    req_idx,
    output logic [ADDR_W-1:0]   req_addr,
    output logic [DATA_W-1:0]   req_data,
    output logic [SIZE_W-1:0]   req_size,
    input  logic                req_ready,
    input  logic                cache_retry,
    input  logic                resp_valid,
    input  logic [IDX_W-1:0]    resp_idx
);
    import sq_pkg::*;

    function automatic logic [IDX_W-1:0] wrap(input logic [IDX_W-1:0] b, input int off);
        int s;
        s = int'(b) + off;
        if (s >= DEPTH) s = s - DEPTH;
        if (s < 0)      s = s + DEPTH;
        return IDX_W'(s);
    endfunction

    // Pointers, occupancy and per-slot flags
    logic [IDX_W-1:0] head_q, wb_q, tail_q;
    logic [CNT_W-1:0] occ, pend_q;
    logic [DEPTH-1:0] elig_q, done_q;
    wb_state_t        state_q, state_nx;

    // Slot payload
    logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
    logic [DEPTH-1:0][DATA_W-1:0] data_q;
    logic [DEPTH-1:0][SIZE_W-1:0] size_q;
    logic [DEPTH-1:0][SEQ_W-1:0]  seq_q;

    logic             alloc_ok, commit_en, wb_live, zero_done, wb_adv, comp_any;
    logic [DEPTH-1:0] mark, kill, retire, comp_vec, done_nx;
    logic [CNT_W-1:0] mark_cnt, kill_cnt, ret_cnt;

    assign alloc_ok  = alloc_valid && !squash_valid && (occ != CNT_W'(DEPTH - 1));
    assign commit_en = commit_valid && !squash_valid;
    assign wb_live   = (pend_q != '0) && (wb_q != tail_q) && elig_q[wb_q];

    sq_commit_scan #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_commit (
        .head(head_q), .occ(occ), .elig(elig_q), .seq(seq_q),
        .en(commit_en), .limit(commit_seq), .mark(mark), .mark_cnt(mark_cnt)
    );

    sq_squash_scan #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_squash (
        .tail(tail_q), .occ(occ), .elig(elig_q), .seq(seq_q),
        .en(squash_valid), .limit(squash_seq), .kill(kill), .kill_cnt(kill_cnt)
    );

    sq_retire_scan #(.DEPTH(DEPTH)) u_retire (
        .head(head_q), .occ(occ), .done(done_nx), .retire(retire), .ret_cnt(ret_cnt)
    );

    // Writeback machine: next state
    always_comb begin
        state_nx  = state_q;
        zero_done = 1'b0;
        wb_adv    = 1'b0;
        unique case (state_q)
            WB_SCAN: begin
                if (wb_live && (size_q[wb_q] == '0)) begin
                    zero_done = !resp_valid;
                end else if (wb_live && !cache_busy) begin
                    state_nx = WB_SEND;
                end
            end
            WB_SEND: begin
                if (req_ready) begin
                    state_nx = WB_SCAN;
                    wb_adv   = 1'b1;
                end else begin
                    state_nx = WB_WAIT_RETRY;
                end
            end
            WB_WAIT_RETRY: begin
                if (cache_retry) state_nx = WB_SEND;
            end
            default: state_nx = WB_SCAN;
        endcase
    end

    // Outputs
    always_comb begin
        int lq_free, sq_free, room;
        req_valid = (state_q == WB_SEND);
        req_idx   = wb_q;
        req_addr  = addr_q[wb_q];
        req_data  = data_q[wb_q];
        req_size  = size_q[wb_q];
        alloc_idx = tail_q;
        lq_free   = LQ_DEPTH - int'(lq_used);
        sq_free   = DEPTH - int'(occ);
        room      = ((lq_free < sq_free) ? lq_free : sq_free) - 1;
        if (room < 0) room = 0;
        free_slots = FREE_W'(room);
    end

    // Completion sources: one per cycle
    always_comb begin
        comp_vec = '0;
        if (resp_valid)     comp_vec[resp_idx] = 1'b1;
        else if (zero_done) comp_vec[wb_q]     = 1'b1;
        comp_any = resp_valid || zero_done;
        done_nx  = done_q | comp_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WB_SCAN;
            head_q  <= '0;
            wb_q    <= '0;
            tail_q  <= '0;
            occ     <= '0;
            pend_q  <= '0;
            elig_q  <= '0;
            done_q  <= '0;
        end else begin
            state_q <= state_nx;
            if (wb_adv || zero_done) wb_q <= wrap(wb_q, 1);
            head_q <= wrap(head_q, int'(ret_cnt));
            tail_q <= alloc_ok ? wrap(tail_q, 1) : wrap(tail_q, -int'(kill_cnt));
            occ    <= occ + CNT_W'(alloc_ok) - ret_cnt - kill_cnt;
            pend_q <= pend_q + mark_cnt - CNT_W'(comp_any);
            elig_q <= (elig_q | mark) & ~retire & ~kill;
            done_q <= done_nx & ~retire & ~kill;
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_ok) begin
            addr_q[tail_q] <= alloc_addr;
            data_q[tail_q] <= alloc_data;
            size_q[tail_q] <= alloc_size;
            seq_q[tail_q]  <= alloc_seq;
        end
    end
endmodule

// File: rtl/store_queue_chk.sv
module store_queue_chk #(
    parameter int DEPTH  = 8,
    parameter int IDX_W  = 3,
    parameter int CNT_W  = 4,
    parameter int SIZE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [IDX_W-1:0]  req_idx,
    input logic [SIZE_W-1:0] req_size,
    input logic              cache_retry,
    input logic              wait_q,
    input logic [CNT_W-1:0]  occ
);
    // R2: never more than DEPTH-1 stores held
    a_r2_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH - 1));

    // R4: an accepted request drops in the following cycle
    a_r4_gap_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_valid);

    // R5: zero-size stores never reach the cache
    a_r5_no_empty_request: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_size != '0));

    // R6: a refused request is withdrawn and keeps its slot
    a_r6_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> !req_valid);
    a_r6_same_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> $stable(req_idx));

    // R7: silent while waiting for the retry pulse
    a_r7_silent_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_q && !cache_retry) |=> !req_valid);
endmodule

bind store_queue store_queue_chk #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .SIZE_W(SIZE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_idx(req_idx), .req_size(req_size), .cache_retry(cache_retry),
    .wait_q(state_q == sq_pkg::WB_WAIT_RETRY), .occ(occ)
);

// File: tb/tb_store_queue.sv
module tb_store_queue;
    localparam int DEPTH = 8, LQ_DEPTH = 8, ADDR_W = 32, DATA_W = 32, SIZE_W = 4, SEQ_W = 16;
    localparam int IDX_W = $clog2(DEPTH), LQ_CNT_W = $clog2(LQ_DEPTH + 1);
    localparam int FREE_W = $clog2(DEPTH + 1);

    localparam logic [ADDR_W-1:0] V_ADDR [4] = '{32'h100, 32'h104, 32'h108, 32'h10C};
    localparam logic [DATA_W-1:0] V_DATA [4] = '{32'hA0, 32'hA1, 32'hA2, 32'hA3};
    localparam logic [SIZE_W-1:0] V_SIZE [4] = '{4'd4, 4'd4, 4'd0, 4'd4};
    localparam logic [SEQ_W-1:0]  V_SEQ  [4] = '{16'd10, 16'd11, 16'd12, 16'd13};

    logic clk = 0, rst_n = 0;
    logic alloc_valid = 0, commit_valid = 0, squash_valid = 0;
    logic [ADDR_W-1:0] alloc_addr = 0;
    logic [DATA_W-1:0] alloc_data = 0;
    logic [SIZE_W-1:0] alloc_size = 0;
    logic [SEQ_W-1:0]  alloc_seq = 0, commit_seq = 0, squash_seq = 0;
    logic [LQ_CNT_W-1:0] lq_used = 0;
    logic cache_busy = 0, req_ready = 0, cache_retry = 0, resp_valid = 0;
    logic [IDX_W-1:0] resp_idx = 0;
    logic [IDX_W-1:0] alloc_idx, req_idx;
    logic [FREE_W-1:0] free_slots;
    logic req_valid;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_data;
    logic [SIZE_W-1:0] req_size;

    int n_chk = 0, n_bad = 0;
    logic finished = 0;

    always #2 clk = ~clk;

    store_queue dut (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [SEQ_W-1:0] s, input logic [SIZE_W-1:0] sz);
        alloc_valid = 1; alloc_seq = s; alloc_size = sz;
        alloc_addr = 32'h200 + s; alloc_data = 32'hD00 + s;
        tick();
        alloc_valid = 0;
    endtask

    task automatic respond(input logic [IDX_W-1:0] i);
        resp_valid = 1; resp_idx = i;
        tick();
        resp_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        check("R1 free", free_slots, 7);
        check("R1 alloc_idx", alloc_idx, 0);
        check("R1 req_valid", req_valid, 0);

        // Vector table: allocate four stores
        for (int i = 0; i < 4; i++) begin
            alloc_valid = 1; alloc_addr = V_ADDR[i]; alloc_data = V_DATA[i];
            alloc_size = V_SIZE[i]; alloc_seq = V_SEQ[i];
            tick();
            check("R2 alloc_idx", alloc_idx, i + 1);
            check("R10 free", free_slots, 6 - i);
        end
        alloc_valid = 0;

        // Commit up to 11, writeback in order
        req_ready = 1;
        commit_valid = 1; commit_seq = 11; tick(); commit_valid = 0;
        check("R4 not yet", req_valid, 0);
        tick();
        check("R4 valid", req_valid, 1);
        check("R4 idx0", req_idx, 0);
        check("R4 addr", req_addr, 32'h100);
        check("R4 data", req_data, 32'hA0);
        tick();
        check("R4 gap", req_valid, 0);
        tick();
        check("R4 idx1", req_idx, 1);
        check("R4 valid1", req_valid, 1);
        tick(); tick(); tick();
        check("R3 uncommitted held", req_valid, 0);
        check("R3 free", free_slots, 3);

        // Out-of-order completion
        respond(1);
        check("R8 non-head frees nothing", free_slots, 3);
        respond(0);
        check("R8 head run retires two", free_slots, 5);

        // Zero-size store
        commit_valid = 1; commit_seq = 12; tick(); commit_valid = 0;
        check("R5 before", free_slots, 5);
        tick();
        check("R5 completes without request", free_slots, 6);
        check("R5 no request", req_valid, 0);
        tick();
        check("R5 still no request", req_valid, 0);

        // Squash stops at committed store; refused request and retry
        put(14, 4);
        check("R2 idx5", alloc_idx, 5);
        put(15, 4);
        check("R10 free4", free_slots, 4);
        req_ready = 0;
        commit_valid = 1; commit_seq = 13; tick(); commit_valid = 0;
        squash_valid = 1; squash_seq = 12; tick(); squash_valid = 0;
        check("R9 tail back", alloc_idx, 4);
        check("R9 free", free_slots, 6);
        check("R4 idx3 raised", req_valid, 1);
        check("R4 idx3", req_idx, 3);
        tick();
        check("R6 withdrawn", req_valid, 0);
        tick();
        check("R7 waiting", req_valid, 0);
        cache_retry = 1; tick(); cache_retry = 0;
        check("R6 resent", req_valid, 1);
        check("R6 same idx", req_idx, 3);
        req_ready = 1; tick();
        check("R6 accepted", req_valid, 0);
        respond(3);
        check("R8 all free", free_slots, 7);

        // Busy cache blocks issue
        cache_busy = 1;
        put(20, 4);
        commit_valid = 1; commit_seq = 20; tick(); commit_valid = 0;
        tick(); tick();
        check("R7 busy", req_valid, 0);
        cache_busy = 0; tick();
        check("R7 after busy", req_valid, 1);
        check("R7 idx4", req_idx, 4);
        tick();
        respond(4);
        check("R8 empty", free_slots, 7);

        // Load-queue limited free count
        lq_used = 6; #1;
        check("R10 lq limited", free_slots, 1);
        lq_used = 0; tick();

        // Fill to full, overflow ignored, then squash all
        for (int i = 0; i < 7; i++) begin
            put(16'(30 + i), 4);
            check("R10 filling", free_slots, 6 - i);
        end
        check("R2 full idx", alloc_idx, 4);
        put(40, 4);
        check("R2 full ignored idx", alloc_idx, 4);
        check("R2 full ignored free", free_slots, 0);
        squash_valid = 1; squash_seq = 29; tick(); squash_valid = 0;
        check("R9 squash all idx", alloc_idx, 5);
        check("R9 squash all free", free_slots, 7);
        tick();
        check("R3 squashed never sent", req_valid, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule